// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds return addresses for a small processor core. It has sixteen slots, each 16 bits wide, and sits apart from both program and data memory. The core raises a push strobe when it executes a call or accepts an interrupt, and the current program counter goes in on the data input. It raises a pop strobe on any return-type instruction, and the saved address then appears on the output.

The slot index is held inside the block. No port can read it or load it, so only push and pop move it. The buffer is circular and never stalls the core. Pushing past the last slot wraps the index to zero and overwrites the oldest entries. Popping below slot zero wraps the index to the last slot. The block drives a single status output that tells software the stack still has room. This flag goes low whenever the index sits at the last slot. Once a push carries the index from the last slot back to zero, the flag stays low until the next reset.

The block has no link to any latch for the upper program-counter bits. Instruction decode and the program counter itself are outside it.

Top module: `ret_addr_stack`

## Requirements
- R1: The storage holds 16 slots of 16 bits, indexed by a 4-bit internal pointer that has no port.
- R2: While `rst` is high at a clock edge, the pointer becomes 0, `avail_o` becomes 1 and `pop_data_o` becomes 16'h0000.
- R3: A push writes `push_data_i` to the slot at the pointer, then moves the pointer up by one modulo 16. After 16 pushes with no pop, the 17th push overwrites the slot written by the 1st push.
- R4: A pop without a push moves the pointer down by one modulo 16. It loads the slot at the new pointer into `pop_data_o`, which shows it from the following cycle. `pop_data_o` holds that value until the next accepted pop.
- R5: `avail_o` is 0 in every cycle in which the pointer is 15. Until a lock occurs, it is 1 at every other pointer value.
- R6: A push at pointer 15 wraps the pointer to 0 and locks `avail_o` at 0 until reset, whatever pops or pushes follow.
- R7: A pop at pointer 0 wraps the pointer to 15, which shows as `avail_o` = 0. No other underflow output exists. A push made after that wrap returns the pointer to 0 and locks the flag, as in R6.
- R8: When push and pop are both high in one cycle, only the push is performed. The pop is ignored, and `pop_data_o` does not change.
- R9: Reset does not clear the slots. A pop made after a reset and before any push returns whatever the slot held before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe (call or interrupt accept) |
| pop_i | input | 1 | Pop strobe (return-type instruction) |
| push_data_i | input | 16 | Address to save |
| pop_data_o | output | 16 | Address taken by the latest pop |
| avail_o | output | 1 | Room-available flag |

## Verification
Some rules hold in every cycle, and the assertions check those: the pointer steps up on each push and down on each lone pop, reset returns the pointer to zero with the flag raised, a wrap past the top slot drops the flag and keeps it low, and a pop that loses to a push leaves the output unchanged. Other behaviour depends on what was stored and read back, and only the bench scenarios can show it. These include last-in-first-out ordering, the overwrite of the oldest slot on the seventeenth push, the value returned by a pop into slots that survived a reset, and the flag recovering after an underflow that no push followed.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    localparam int unsigned RSTK_DATA_W = 16;
    localparam int unsigned RSTK_PTR_W  = 4;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    typedef struct packed {
        stk_op_e op;
        logic    at_top;
    } stk_step_t;

    // Push wins over pop when both are requested.
    function automatic stk_op_e stk_arbitrate(input logic push, input logic pop);
        if (push)      return STK_PUSH;
        else if (pop)  return STK_POP;
        else           return STK_IDLE;
    endfunction

endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int unsigned PTR_W = RSTK_PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    output stk_op_e          op_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic             avail_o
);

    localparam logic [PTR_W-1:0] PTR_TOP  = {PTR_W{1'b1}};
    localparam logic [PTR_W-1:0] PTR_ZERO = '0;
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    logic [PTR_W-1:0] ptr_q;
    logic             lock_q;
    stk_step_t        step;

    always_comb begin
        step.op     = stk_arbitrate(push_i, pop_i);
        step.at_top = (ptr_q == PTR_TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= PTR_ZERO;
            lock_q <= 1'b0;
        end else begin
            unique case (step.op)
                STK_PUSH: begin
                    ptr_q <= ptr_q + PTR_ONE;
                    if (step.at_top) lock_q <= 1'b1;
                end
                STK_POP:  ptr_q <= ptr_q - PTR_ONE;
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    assign op_o     = step.op;
    assign wr_ptr_o = ptr_q;
    assign rd_ptr_o = ptr_q - PTR_ONE;
    assign avail_o  = ~lock_q & ~step.at_top;

    // R2: reset leaves pointer at zero with the flag raised
    a_r2_reset_state: assert property (@(posedge clk)
        rst |=> (ptr_q == PTR_ZERO && avail_o));

    // R3: every push advances the pointer by one
    a_r3_push_advance: assert property (@(posedge clk) disable iff (rst)
        push_i |=> (ptr_q == $past(ptr_q) + PTR_ONE));

    // R4: a lone pop steps the pointer back by one
    a_r4_pop_retreat: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> (ptr_q == $past(ptr_q) - PTR_ONE));

    // R6: a push at the top slot wraps to zero with the flag low
    a_r6_wrap_locks: assert property (@(posedge clk) disable iff (rst)
        (push_i && ptr_q == PTR_TOP) |=> (ptr_q == PTR_ZERO && !avail_o));

    // R6: a low flag away from the top slot means it is locked and stays low
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (!avail_o && ptr_q != PTR_TOP) |=> !avail_o);

endmodule

// File: rtl/rstk_mem.sv
module rstk_mem #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [PTR_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Slots keep their contents across reset.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we_i && waddr_i == PTR_W'(g)) slot_q[g] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_q <= '0;
        else if (re_i) rdata_q <= slot_q[raddr_i];
    end

    assign rdata_o = rdata_q;

    // R4: the output register only changes on an accepted pop
    a_r4_read_holds: assert property (@(posedge clk) disable iff (rst)
        !re_i |=> $stable(rdata_o));

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import rstk_pkg::*;
#(
    parameter int unsigned DATA_W = RSTK_DATA_W,
    parameter int unsigned PTR_W  = RSTK_PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              avail_o
);

    stk_op_e          op;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    rstk_ctrl #(.PTR_W(PTR_W)) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .op_o     (op),
        .wr_ptr_o (wr_ptr),
        .rd_ptr_o (rd_ptr),
        .avail_o  (avail_o)
    );

    rstk_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_mem (
        .clk     (clk),
        .rst     (rst),
        .we_i    (op == STK_PUSH),
        .waddr_i (wr_ptr),
        .wdata_i (push_data_i),
        .re_i    (op == STK_POP),
        .raddr_i (rd_ptr),
        .rdata_o (pop_data_o)
    );

    // R8: a pop that coincides with a push leaves the output untouched
    a_r8_push_wins: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> $stable(pop_data_o));

endmodule

// File: tb/test_ret_addr_stack.sv
`timescale 1ns/1ps
module test_ret_addr_stack;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [15:0] push_data_i = '0;
    logic [15:0] pop_data_o;
    logic        avail_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ret_addr_stack i_ret_addr_stack (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .pop_data_o(pop_data_o), .avail_o(avail_o)
    );

    typedef struct packed {
        logic        push;
        logic        pop;
        logic [15:0] data;
        logic [15:0] exp_data;
        logic        exp_avail;
    } vec_t;

    // Starts right after reset, pointer 0.
    localparam vec_t VECS [11] = '{
        '{1'b1, 1'b0, 16'h1000, 16'h0000, 1'b1},  // R3 push to 0
        '{1'b1, 1'b0, 16'h1001, 16'h0000, 1'b1},  // R3 push to 1
        '{1'b1, 1'b0, 16'h1002, 16'h0000, 1'b1},  // R3 push to 2
        '{1'b0, 1'b1, 16'h0000, 16'h1002, 1'b1},  // R4 pop slot 2
        '{1'b1, 1'b0, 16'h1003, 16'h1002, 1'b1},  // R3 reuse slot 2
        '{1'b1, 1'b1, 16'h2000, 16'h1002, 1'b1},  // R8 both: push only
        '{1'b0, 1'b1, 16'h0000, 16'h2000, 1'b1},  // R4 pop slot 3
        '{1'b0, 1'b1, 16'h0000, 16'h1003, 1'b1},  // R4 pop slot 2
        '{1'b0, 1'b1, 16'h0000, 16'h1001, 1'b1},  // R4 pop slot 1
        '{1'b0, 1'b1, 16'h0000, 16'h1000, 1'b1},  // R4 pop slot 0
        '{1'b0, 1'b0, 16'h0000, 16'h1000, 1'b1}   // R4 idle holds
    };

    task automatic check(input string req, input logic [15:0] exp_d, input logic exp_a);
        checks++;
        if (pop_data_o !== exp_d || avail_o !== exp_a) begin
            failures++;
            $display("FAIL %s: pop_data=%h avail=%b expected pop_data=%h avail=%b",
                     req, pop_data_o, avail_o, exp_d, exp_a);
        end
    endtask

    // Drive inputs for one edge; returns 1 ns after the edge.
    task automatic step(input logic p, input logic q, input logic [15:0] d);
        push_i = p; pop_i = q; push_data_i = d;
        @(posedge clk); #1;
        push_i = 1'b0; pop_i = 1'b0; push_data_i = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        check("R2 reset state", 16'h0000, 1'b1);

        for (int i = 0; i < 11; i++) begin
            step(VECS[i].push, VECS[i].pop, VECS[i].data);
            check($sformatf("R3/R4/R8 vector %0d", i), VECS[i].exp_data, VECS[i].exp_avail);
        end

        // Fill all 16 slots (R1, R5, R6)
        do_reset();
        for (int k = 0; k < 16; k++) begin
            step(1'b1, 1'b0, 16'hC000 + 16'(k));
            if (k == 13) check("R5 pointer 14 flag high", 16'h0000, 1'b1);
            if (k == 14) check("R5 pointer 15 flag low", 16'h0000, 1'b0);
            if (k == 15) check("R6 wrap to 0 locks flag", 16'h0000, 1'b0);
        end
        step(1'b1, 1'b0, 16'hD000);
        check("R6 lock after further push", 16'h0000, 1'b0);
        step(1'b0, 1'b1, 16'h0000);
        check("R3 17th push overwrote slot 0", 16'hD000, 1'b0);
        step(1'b0, 1'b1, 16'h0000);
        check("R1 slot 15 intact", 16'hC00F, 1'b0);
        step(1'b0, 1'b1, 16'h0000);
        check("R6 flag stays low at pointer 14", 16'hC00E, 1'b0);
        for (int k = 13; k >= 1; k--) begin
            step(1'b0, 1'b1, 16'h0000);
            check($sformatf("R1 slot %0d readback", k), 16'hC000 + 16'(k), 1'b0);
        end

        // Underflow without a following push (R7, R9, R5)
        do_reset();
        check("R2 reset clears lock", 16'h0000, 1'b1);
        step(1'b0, 1'b1, 16'h0000);
        check("R7 pop at 0 wraps to 15, R9 old slot 15", 16'hC00F, 1'b0);
        step(1'b0, 1'b1, 16'h0000);
        check("R5 flag recovers at pointer 14", 16'hC00E, 1'b1);

        // Underflow followed by a push locks (R7)
        do_reset();
        step(1'b0, 1'b1, 16'h0000);
        check("R9 pop before push returns old slot 15", 16'hC00F, 1'b0);
        step(1'b1, 1'b0, 16'hABCD);
        check("R7 push after underflow", 16'hC00F, 1'b0);
        step(1'b0, 1'b1, 16'h0000);
        check("R7 pop returns pushed value", 16'hABCD, 1'b0);
        step(1'b0, 1'b1, 16'h0000);
        check("R7 flag locked at pointer 14", 16'hC00E, 1'b0);

        // R8: simultaneous strobes at the top slot still wrap and lock
        do_reset();
        for (int k = 0; k < 15; k++) step(1'b1, 1'b0, 16'h5000 + 16'(k));
        step(1'b1, 1'b1, 16'h5FFF);
        check("R8 push wins at top, locks", 16'h0000, 1'b0);
        step(1'b0, 1'b1, 16'h0000);
        check("R8 pushed value stored in slot 15", 16'h5FFF, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule